// File: doc/BRIEF.md
# Incremental encoder pulse decoder

This block sits between the position-sensor pins of a motion or measurement front end and a 24-bit up/down counter that lives elsewhere. It registers the raw A/UP, B/DN and Z/CLR inputs on the rising clock edge. From the registered values it produces a one-cycle count enable with an up/down flag, a one-cycle clear strobe for the counter, and a sticky flag for illegal quadrature steps.

A static mode input and a 3-bit edge select choose one of eight input formats. Two-phase quadrature input can be counted at one, two or four counts per cycle, with the index clear either asynchronous or synchronous. Single-pulse input counts A edges while B is high. Separate up and down pulse inputs are also supported. A direction-flip input inverts the decoded direction.

A two-bit index command chooses whether Z pulses are ignored, honoured once or honoured every time. An error-clear strobe drops the illegal-step flag.

The phase discriminator is a four-state machine whose states are the last sampled AB pair: AB_00, AB_01, AB_11 and AB_10. Its transitions are classified into four kinds:
- forward step: 00→10→11→01→00, where A leads, which counts up;
- backward step: the reverse order, which counts down;
- hold: no change;
- jump: both bits change.

The index qualifier is a three-state machine:
- IDX_OFF moves to IDX_ONCE or IDX_EVERY on the matching command.
- IDX_ONCE fires on one qualified index event and then drops to IDX_OFF.
- IDX_EVERY fires on every qualified event.
- Any state moves to IDX_OFF on the ignore command.

Top module: `enc_decoder`

## Requirements
- R1: Each output reacts two clock edges after an input change that is set up before a rising edge: one edge samples, one edge registers. After reset, cnt_en, clr_stb and ai_flag are 0 and cnt_up is 1. Reset reloads the phase state from the inputs, so the first cycles after reset give no count and no error. cnt_en and clr_stb are one-cycle strobes.
- R2: With ud_mode=0 and sel=010 or 110 (four counts per cycle), every single-bit AB change counts. AB is written {A,B}. The steps 00→10, 10→11, 11→01 and 01→00 count up, and the reverse steps count down.
- R3: With sel=001 or 101 (two counts per cycle), only AB steps in which A changes count. Their direction follows R2.
- R4: With sel=000 or 100 (one count per cycle), only the steps between AB=00 and AB=10 count: 00→10 counts up and 10→00 counts down.
- R5: With sel=011, a rising A edge counts up while the sampled B is 1. With sel=111, both A edges count up while B is 1. When B is 0, nothing counts.
- R6: With ud_mode=1, a rising edge on A counts up and a rising edge on B counts down. Falling edges do not count. When both inputs rise in the same sample, nothing counts.
- R7: dir_flip=1 inverts the decoded direction. cnt_up reports the direction of the last count (1 for up, 0 for down) and changes only together with a count.
- R8: In quadrature modes, a step in which both A and B change gives no count and sets ai_flag. The flag stays set until reset or ai_clr, and ai_clr wins over a new bad step in the same cycle. Single-pulse and up/down modes never set the flag.
- R9: In up/down mode, single-pulse mode and quadrature modes with sel[2]=0, a rising edge of the sampled Z gives a qualified index event.
- R10: With sel=100, 101 or 110, the qualified index event is any A change in a sample where Z=1 and B=0. A Z edge on its own does nothing.
- R11: The index command on zcmd, taken when zcmd_wr=1, is encoded as follows: 00 keeps the current setting, 01 ignores Z, 10 honours only the next event, and 11 honours every event. Reset selects ignore. An honoured event gives clr_stb, and in the once setting that event also disables further clears.
- R12: When a synchronous index event falls on a counted A step, cnt_en and clr_stb are both asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ud_mode | input | 1 | 1 selects separate up/down pulse inputs |
| sel | input | 3 | Edge evaluation and clear-mode select (static) |
| dir_flip | input | 1 | 1 inverts the decoded direction |
| a_in | input | 1 | Phase A or up pulse input |
| b_in | input | 1 | Phase B, gate or down pulse input |
| z_in | input | 1 | Index / clear input |
| zcmd_wr | input | 1 | Strobe that takes zcmd |
| zcmd | input | 2 | Index command: keep, ignore, once, every |
| ai_clr | input | 1 | Clears the illegal-step flag |
| cnt_en | output | 1 | One-cycle count enable |
| cnt_up | output | 1 | Direction of the last count, 1 = up |
| clr_stb | output | 1 | One-cycle counter clear strobe |
| ai_flag | output | 1 | Sticky illegal quadrature step flag |

## Verification
In the synchronous clear setting, an A step taken while Z is high and B is low is both a count and an index event. The bench raises Z first with AB held, then moves A from 0 to 1. It expects cnt_en and clr_stb high in the same sample, two edges later. The second coincidence is ai_clr landing in the cycle in which a bad step is registered. The bench drives that strobe one edge after the jump is sampled and expects the flag to stay low afterwards.

// File: rtl/enc_pkg.sv
package enc_pkg;

    typedef enum logic [1:0] {
        AB_00 = 2'b00,
        AB_01 = 2'b01,
        AB_10 = 2'b10,
        AB_11 = 2'b11
    } ab_state_t;

    typedef enum logic [1:0] {
        MODE_QUAD   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_UPDN   = 2'd2
    } pulse_mode_t;

    typedef enum logic [1:0] {
        EVAL_X1 = 2'd0,
        EVAL_X2 = 2'd1,
        EVAL_X4 = 2'd2
    } eval_t;

    typedef enum logic [1:0] {
        IDX_OFF   = 2'd0,
        IDX_ONCE  = 2'd1,
        IDX_EVERY = 2'd2
    } idx_state_t;

    localparam int ZCMD_W = 2;
    localparam logic [ZCMD_W-1:0] ZC_KEEP   = 2'b00;
    localparam logic [ZCMD_W-1:0] ZC_IGNORE = 2'b01;
    localparam logic [ZCMD_W-1:0] ZC_ONCE   = 2'b10;
    localparam logic [ZCMD_W-1:0] ZC_EVERY  = 2'b11;

    localparam int SEL_W = 3;

    typedef struct packed {
        pulse_mode_t mode;
        eval_t       eval;
        logic        sync_clr;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(input logic ud, input logic [SEL_W-1:0] sel);
        mode_cfg_t c;
        c.mode     = MODE_QUAD;
        c.eval     = EVAL_X1;
        c.sync_clr = 1'b0;
        if (ud) begin
            c.mode = MODE_UPDN;
        end else begin
            unique case (sel)
                3'b000, 3'b100: c.eval = EVAL_X1;
                3'b001, 3'b101: c.eval = EVAL_X2;
                3'b010, 3'b110: c.eval = EVAL_X4;
                3'b011: begin
                    c.mode = MODE_SINGLE;
                    c.eval = EVAL_X1;
                end
                3'b111: begin
                    c.mode = MODE_SINGLE;
                    c.eval = EVAL_X2;
                end
            endcase
            c.sync_clr = sel[2] && (sel != 3'b111);
        end
        return c;
    endfunction

endpackage

// File: rtl/enc_sampler.sv
module enc_sampler #(
    parameter int STAGES = 1,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur
);

    logic [W-1:0] cur_q;

    generate
        if (STAGES <= 1) begin : g_single
            always_ff @(posedge clk) begin
                cur_q <= raw;
            end
        end else begin : g_chain
            logic [W-1:0] chain [STAGES-1];
            always_ff @(posedge clk) begin
                chain[0] <= raw;
                for (int i = 1; i < STAGES - 1; i++) begin
                    chain[i] <= chain[i-1];
                end
                cur_q <= chain[STAGES-2];
            end
        end
    endgenerate

    assign cur = cur_q;

endmodule

// File: rtl/enc_phase_fsm.sv
module enc_phase_fsm
    import enc_pkg::*;
(
    input  logic clk,
    input  logic cur_a,
    input  logic cur_b,
    output logic q_move,
    output logic q_up,
    output logic q_jump,
    output logic q_x1,
    output logic a_chg,
    output logic a_rise,
    output logic a_fall,
    output logic b_rise
);

    ab_state_t  st;
    logic [1:0] nab;
    logic [1:0] pab;

    assign nab = {cur_a, cur_b};
    assign pab = st;

    // State register: always follows the newest sample, so a reset
    // of the sampling path leaves it on the current AB pair.
    always_ff @(posedge clk) begin
        st <= ab_state_t'(nab);
    end

    // Transition classification.
    always_comb begin
        q_move = 1'b0;
        q_up   = 1'b0;
        q_jump = 1'b0;
        q_x1   = 1'b0;
        unique case (st)
            AB_00: begin
                case (nab)
                    2'b10: begin q_move = 1'b1; q_up = 1'b1; q_x1 = 1'b1; end
                    2'b01: begin q_move = 1'b1; q_up = 1'b0; end
                    2'b11: q_jump = 1'b1;
                    default: ;
                endcase
            end
            AB_10: begin
                case (nab)
                    2'b11: begin q_move = 1'b1; q_up = 1'b1; end
                    2'b00: begin q_move = 1'b1; q_up = 1'b0; q_x1 = 1'b1; end
                    2'b01: q_jump = 1'b1;
                    default: ;
                endcase
            end
            AB_11: begin
                case (nab)
                    2'b01: begin q_move = 1'b1; q_up = 1'b1; end
                    2'b10: begin q_move = 1'b1; q_up = 1'b0; end
                    2'b00: q_jump = 1'b1;
                    default: ;
                endcase
            end
            AB_01: begin
                case (nab)
                    2'b00: begin q_move = 1'b1; q_up = 1'b1; end
                    2'b11: begin q_move = 1'b1; q_up = 1'b0; end
                    2'b10: q_jump = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign a_chg  = pab[1] ^ cur_a;
    assign a_rise = cur_a & ~pab[1];
    assign a_fall = ~cur_a & pab[1];
    assign b_rise = cur_b & ~pab[0];

endmodule

// File: rtl/enc_index_fsm.sv
module enc_index_fsm
    import enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              cur_z,
    input  logic              cur_b,
    input  logic              a_chg,
    input  logic              cmd_wr,
    input  logic [ZCMD_W-1:0] cmd,
    output logic              fire
);

    idx_state_t st;
    idx_state_t nxt;
    logic       z_prev;
    logic       evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= IDX_OFF;
            z_prev <= cur_z;
        end else begin
            st     <= nxt;
            z_prev <= cur_z;
        end
    end

    assign evt = sync_mode ? (a_chg & cur_z & ~cur_b) : (cur_z & ~z_prev);

    // Next state: auto-disable after a honoured event, command overrides.
    always_comb begin
        nxt = st;
        unique case (st)
            IDX_OFF:   nxt = IDX_OFF;
            IDX_ONCE:  nxt = evt ? IDX_OFF : IDX_ONCE;
            IDX_EVERY: nxt = IDX_EVERY;
            default:   nxt = IDX_OFF;
        endcase
        if (cmd_wr) begin
            case (cmd)
                ZC_IGNORE: nxt = IDX_OFF;
                ZC_ONCE:   nxt = IDX_ONCE;
                ZC_EVERY:  nxt = IDX_EVERY;
                default:   ;
            endcase
        end
    end

    // Output: honoured event.
    always_comb begin
        fire = 1'b0;
        unique case (st)
            IDX_ONCE, IDX_EVERY: fire = evt;
            default:             fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/enc_decoder.sv
module enc_decoder
    import enc_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ud_mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic              dir_flip,
    input  logic              a_in,
    input  logic              b_in,
    input  logic              z_in,
    input  logic              zcmd_wr,
    input  logic [ZCMD_W-1:0] zcmd,
    input  logic              ai_clr,
    output logic              cnt_en,
    output logic              cnt_up,
    output logic              clr_stb,
    output logic              ai_flag
);

    localparam int IN_W = 3;

    logic [IN_W-1:0] smp;
    logic            s_a, s_b, s_z;
    mode_cfg_t       cfg;

    logic q_move, q_up, q_jump, q_x1;
    logic a_chg, a_rise, a_fall, b_rise;
    logic idx_fire;

    logic step_en, step_up, step_bad;

    enc_sampler #(.STAGES(IN_STAGES), .W(IN_W)) u_smp (
        .clk (clk),
        .raw ({a_in, b_in, z_in}),
        .cur (smp)
    );

    assign {s_a, s_b, s_z} = smp;
    assign cfg = decode_mode(ud_mode, sel);

    enc_phase_fsm u_phase (
        .clk    (clk),
        .cur_a  (s_a),
        .cur_b  (s_b),
        .q_move (q_move),
        .q_up   (q_up),
        .q_jump (q_jump),
        .q_x1   (q_x1),
        .a_chg  (a_chg),
        .a_rise (a_rise),
        .a_fall (a_fall),
        .b_rise (b_rise)
    );

    enc_index_fsm u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (cfg.sync_clr),
        .cur_z     (s_z),
        .cur_b     (s_b),
        .a_chg     (a_chg),
        .cmd_wr    (zcmd_wr),
        .cmd       (zcmd),
        .fire      (idx_fire)
    );

    // Per-mode step decode.
    always_comb begin
        step_en  = 1'b0;
        step_up  = 1'b1;
        step_bad = 1'b0;
        unique case (cfg.mode)
            MODE_QUAD: begin
                unique case (cfg.eval)
                    EVAL_X1: step_en = q_x1;
                    EVAL_X2: step_en = q_move & a_chg;
                    EVAL_X4: step_en = q_move;
                    default: step_en = 1'b0;
                endcase
                step_up  = q_up;
                step_bad = q_jump;
            end
            MODE_SINGLE: begin
                step_en = s_b & (a_rise | ((cfg.eval == EVAL_X2) & a_fall));
                step_up = 1'b1;
            end
            MODE_UPDN: begin
                step_en = a_rise ^ b_rise;
                step_up = a_rise;
            end
            default: ;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en  <= 1'b0;
            cnt_up  <= 1'b1;
            clr_stb <= 1'b0;
            ai_flag <= 1'b0;
        end else begin
            cnt_en  <= step_en;
            clr_stb <= idx_fire;
            if (step_en) begin
                cnt_up <= step_up ^ dir_flip;
            end
            if (ai_clr) begin
                ai_flag <= 1'b0;
            end else if (step_bad) begin
                ai_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/enc_decoder_chk.sv
module enc_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ud_mode,
    input logic [2:0] sel,
    input logic       zcmd_wr,
    input logic [1:0] zcmd,
    input logic       ai_clr,
    input logic       cnt_en,
    input logic       cnt_up,
    input logic       clr_stb,
    input logic       ai_flag
);

    logic quad_sel;
    assign quad_sel = !ud_mode && (sel != 3'b011) && (sel != 3'b111);

    AST_AI_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ai_flag && !ai_clr) |=> ai_flag); // R8
    AST_AI_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) ai_clr |=> !ai_flag); // R8
    AST_NO_AI_OUTSIDE_QUAD: assert property (@(posedge clk) disable iff (!rst_n) !quad_sel |=> !$rose(ai_flag)); // R8
    AST_JUMP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(ai_flag) |-> !cnt_en); // R2
    AST_DIR_ONLY_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cnt_up) |-> cnt_en); // R7
    AST_IGNORE_BLOCKS_CLR: assert property (@(posedge clk) disable iff (!rst_n) (zcmd_wr && zcmd == 2'b01) |=> ##1 !clr_stb); // R11

endmodule

bind enc_decoder enc_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ud_mode (ud_mode),
    .sel     (sel),
    .zcmd_wr (zcmd_wr),
    .zcmd    (zcmd),
    .ai_clr  (ai_clr),
    .cnt_en  (cnt_en),
    .cnt_up  (cnt_up),
    .clr_stb (clr_stb),
    .ai_flag (ai_flag)
);

// File: tb/enc_decoder_tb.sv
module enc_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ud_mode = 1'b0;
    logic [2:0] sel = 3'b010;
    logic       dir_flip = 1'b0;
    logic       a_in = 1'b1, b_in = 1'b1, z_in = 1'b0;
    logic       zcmd_wr = 1'b0;
    logic [1:0] zcmd = 2'b00;
    logic       ai_clr = 1'b0;
    logic       cnt_en, cnt_up, clr_stb, ai_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ud_mode(ud_mode), .sel(sel), .dir_flip(dir_flip),
        .a_in(a_in), .b_in(b_in), .z_in(z_in), .zcmd_wr(zcmd_wr), .zcmd(zcmd),
        .ai_clr(ai_clr), .cnt_en(cnt_en), .cnt_up(cnt_up), .clr_stb(clr_stb),
        .ai_flag(ai_flag)
    );

    typedef struct packed {
        logic       ud;
        logic [2:0] sel;
        logic       flip;
        logic [1:0] ab0;
        logic [1:0] ab1;
        logic       en;
        logic       up;
        logic       ai;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        // R2 four counts per cycle
        '{1'b0, 3'b010, 1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b0, 3'b010, 1'b0, 2'b10, 2'b11, 1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b0, 3'b010, 1'b0, 2'b11, 2'b01, 1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b0, 3'b010, 1'b0, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 4'd2},
        '{1'b0, 3'b010, 1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 4'd2},
        '{1'b0, 3'b010, 1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 4'd2},
        // R8 jumps
        '{1'b0, 3'b010, 1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 4'd8},
        '{1'b0, 3'b010, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 4'd8},
        // R3 two counts per cycle
        '{1'b0, 3'b001, 1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 4'd3},
        '{1'b0, 3'b001, 1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b0, 3'b001, 1'b0, 2'b11, 2'b01, 1'b1, 1'b1, 1'b0, 4'd3},
        '{1'b0, 3'b001, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd3},
        '{1'b0, 3'b001, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4'd3},
        // R4 one count per cycle
        '{1'b0, 3'b000, 1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b0, 3'b000, 1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 4'd4},
        '{1'b0, 3'b000, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 3'b000, 1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 4'd4},
        // R2 synchronous clear variant counts the same
        '{1'b0, 3'b110, 1'b0, 2'b10, 2'b11, 1'b1, 1'b1, 1'b0, 4'd2},
        // R7 direction flip
        '{1'b0, 3'b010, 1'b1, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, 3'b010, 1'b1, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 4'd7},
        // R5 single pulse
        '{1'b0, 3'b011, 1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 4'd5},
        '{1'b0, 3'b011, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 3'b011, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 3'b111, 1'b0, 2'b11, 2'b01, 1'b1, 1'b1, 1'b0, 4'd5},
        '{1'b0, 3'b111, 1'b1, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd7},
        // R8 single pulse never flags
        '{1'b0, 3'b011, 1'b0, 2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 4'd8},
        // R6 up/down pulses
        '{1'b1, 3'b000, 1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 4'd6},
        '{1'b1, 3'b000, 1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 4'd6},
        '{1'b1, 3'b000, 1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 3'b000, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 3'b000, 1'b1, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0, 4'd7}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    task automatic set_ab(input logic [1:0] ab);
        a_in = ab[1];
        b_in = ab[0];
    endtask

    task automatic zcommand(input logic [1:0] c);
        zcmd = c;
        zcmd_wr = 1'b1;
        tick();
        zcmd_wr = 1'b0;
        repeat (2) tick();
    endtask

    task automatic clear_ai();
        ai_clr = 1'b1;
        tick();
        ai_clr = 1'b0;
        repeat (2) tick();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state with non-zero inputs held through reset
        repeat (4) tick();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(cnt_en, 1'b0, "R1", "cnt_en after reset");
            chk(ai_flag, 1'b0, "R1", "ai_flag after reset");
            chk(clr_stb, 1'b0, "R1", "clr_stb after reset");
            chk(cnt_up, 1'b1, "R1", "cnt_up after reset");
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            ud_mode = VEC[i].ud;
            sel = VEC[i].sel;
            dir_flip = VEC[i].flip;
            set_ab(VEC[i].ab0);
            repeat (4) tick();
            clear_ai();
            set_ab(VEC[i].ab1);
            repeat (LAT) tick();
            chk(cnt_en, VEC[i].en, rq, $sformatf("vec%0d cnt_en", i));
            if (VEC[i].en) chk(cnt_up, VEC[i].up, rq, $sformatf("vec%0d cnt_up", i));
            chk(ai_flag, VEC[i].ai, rq, $sformatf("vec%0d ai_flag", i));
            tick();
            chk(cnt_en, 1'b0, "R1", $sformatf("vec%0d strobe width", i));
        end

        // R8 sticky flag and clear priority
        ud_mode = 1'b0; sel = 3'b010; dir_flip = 1'b0;
        set_ab(2'b00); repeat (4) tick(); clear_ai();
        set_ab(2'b11); repeat (LAT) tick();
        chk(ai_flag, 1'b1, "R8", "flag set by jump");
        set_ab(2'b01); repeat (3) tick();
        set_ab(2'b00); repeat (3) tick();
        chk(ai_flag, 1'b1, "R8", "flag sticky across legal steps");
        clear_ai();
        chk(ai_flag, 1'b0, "R8", "flag cleared");
        set_ab(2'b11);
        tick();
        ai_clr = 1'b1;
        tick();
        ai_clr = 1'b0;
        chk(ai_flag, 1'b0, "R8", "clear wins over coincident jump");
        repeat (2) tick();
        chk(ai_flag, 1'b0, "R8", "flag stays low after coincident clear");

        // R11 reset default ignores Z; R9 asynchronous clear
        set_ab(2'b00); repeat (3) tick();
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R11", "default ignore blocks clear");
        z_in = 1'b0; repeat (3) tick();
        zcommand(2'b11);
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b1, "R9", "rising Z clears");
        tick();
        chk(clr_stb, 1'b0, "R9", "clear strobe one cycle");
        z_in = 1'b0; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R9", "falling Z no clear");
        zcommand(2'b00);
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b1, "R11", "keep command retains every");
        z_in = 1'b0; repeat (3) tick();
        zcommand(2'b01);
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R11", "ignore blocks clear");
        z_in = 1'b0; repeat (3) tick();
        zcommand(2'b10);
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b1, "R11", "once honours first pulse");
        z_in = 1'b0; repeat (3) tick();
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R11", "once auto-disables");
        z_in = 1'b0; repeat (3) tick();

        // R10 / R12 synchronous clear
        sel = 3'b110;
        zcommand(2'b11);
        set_ab(2'b00); repeat (3) tick();
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R10", "Z edge alone no sync clear");
        repeat (2) tick();
        set_ab(2'b10); repeat (LAT) tick();
        chk(clr_stb, 1'b1, "R12", "sync clear on A edge");
        chk(cnt_en, 1'b1, "R12", "count in same cycle as clear");
        chk(cnt_up, 1'b1, "R12", "direction in clear cycle");
        tick();
        chk(clr_stb, 1'b0, "R10", "sync clear one cycle");
        set_ab(2'b11); repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R10", "B edge no sync clear");
        set_ab(2'b01); repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R10", "A edge with B high no sync clear");
        z_in = 1'b0; repeat (3) tick();

        // R1 reset resynchronises phase state and clears the flag
        sel = 3'b010;
        set_ab(2'b00); repeat (3) tick();
        set_ab(2'b11); repeat (LAT) tick();
        chk(ai_flag, 1'b1, "R8", "flag set before reset");
        set_ab(2'b10);
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(ai_flag, 1'b0, "R1", "flag low after mid-run reset");
            chk(cnt_en, 1'b0, "R1", "no count after mid-run reset");
        end
        z_in = 1'b1; repeat (LAT) tick();
        chk(clr_stb, 1'b0, "R11", "reset returns index to ignore");
        z_in = 1'b0; tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule